// File: doc/BRIEF.md
# 100 Mb/s Receive Code-Group Error Monitor

This block sits on the receive side of a 100 Mb/s link, after the 5-bit code groups have been recovered and aligned. It tracks frame boundaries from the start and end delimiters. It reports three kinds of receive fault:

- a carrier that does not open with a proper start delimiter (false carrier);
- a code group inside a frame that is neither data nor a defined control code (invalid symbol);
- a halt code group inside a frame (halt symbol).

Each fault produces a one-cycle receive-error pulse toward the MAC side. Each fault also sets its own sticky flag in a 16-bit management status word. A flag stays set until software reads the word. A read returns the flags as they stand in the read cycle and clears them, except for any flag whose fault arrives in that same cycle. When the mode input selects 10 Mb/s operation, the symbol stream is ignored and all three flags read as zero.

Top module: `rx_symerr_mon`

## Requirements
- R1: From idle, a /J/ (11000) followed by a /K/ (10001) on consecutive accepted groups opens a frame. `in_frame` reads 1 from the clock edge that accepts /K/ onward, and no error is raised.
- R2: From idle, two consecutive accepted non-idle groups (idle is 11111) that are not /J/ then /K/ are a false carrier. They give a one-cycle `rx_err` pulse on the second group and set status bit 8. The monitor then waits for an idle group before it looks for carrier again.
- R3: Inside a frame, a group that is none of the 16 data codes and none of J, K, T (01101), R (00111), H (00100) or idle gives a one-cycle `rx_err` pulse and sets status bit 7.
- R4: Inside a frame, a halt group (00100) gives a one-cycle `rx_err` pulse and sets status bit 6. The frame continues.
- R5: A frame ends on /T/ then /R/, or on any idle group; `in_frame` drops at the edge that accepts that group. A /T/ followed by anything other than /R/ or idle keeps the frame open.
- R6: A set status flag stays at 1 across later cycles without a read, even after the condition is gone.
- R7: With `rd_stb` high, `status_word` in that cycle shows the held flags. After that edge, every flag with no new event reads 0.
- R8: An event accepted in the same cycle as a read leaves its flag at 1 after the read.
- R9: While `mode_100` is 0, all three flags are 0, groups are ignored, and `in_frame` and `rx_err` stay 0. Any flag set earlier is cleared.
- R10: After reset all outputs are 0. Status bits other than 8, 7 and 6 are always 0.
- R11: Outside a frame, a single non-idle group followed by idle is not a carrier and raises no error, even if that group is invalid or a halt.
- R12: A cycle with `cg_valid` low is ignored: state is held and `rx_err` is 0 for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_100 | input | 1 | 1 = 100 Mb/s operation, 0 = 10 Mb/s operation |
| cg_valid | input | 1 | Qualifies `cg_data` for this cycle |
| cg_data | input | 5 | Received code group |
| rd_stb | input | 1 | Management read of the status word |
| rx_err | output | 1 | Registered receive-error pulse, one cycle per fault |
| in_frame | output | 1 | Registered frame-reception indication |
| status_word | output | 16 | Status word; bit 8 false carrier, bit 7 invalid symbol, bit 6 halt |

## Verification
The assertions assume that every input is driven to a known level after reset, and that the inputs only change between rising edges. They also take `mode_100` as a slow control that is sampled once per edge, like the other inputs, with no particular alignment to frames. The stimulus therefore drives every input at the falling clock edge and holds it for a full period. It switches the mode only between groups, and it keeps `rd_stb` to single cycles, so that each read can be matched to one expected snapshot of the flags.

// File: rtl/rxmon_pkg.sv
package rxmon_pkg;

  localparam int CG_W = 5;

  localparam logic [CG_W-1:0] CG_J    = 5'b11000;
  localparam logic [CG_W-1:0] CG_K    = 5'b10001;
  localparam logic [CG_W-1:0] CG_T    = 5'b01101;
  localparam logic [CG_W-1:0] CG_R    = 5'b00111;
  localparam logic [CG_W-1:0] CG_H    = 5'b00100;
  localparam logic [CG_W-1:0] CG_IDLE = 5'b11111;

  localparam int NUM_DATA  = 16;
  localparam int NUM_FLAGS = 3;
  localparam int FLG_FC    = 0;
  localparam int FLG_INV   = 1;
  localparam int FLG_HALT  = 2;

  // 4-bit nibble to 5-bit data code group
  function automatic logic [CG_W-1:0] data_code(input int unsigned nib);
    logic [CG_W-1:0] c;
    case (nib)
      0:  c = 5'b11110;
      1:  c = 5'b01001;
      2:  c = 5'b10100;
      3:  c = 5'b10101;
      4:  c = 5'b01010;
      5:  c = 5'b01011;
      6:  c = 5'b01110;
      7:  c = 5'b01111;
      8:  c = 5'b10010;
      9:  c = 5'b10011;
      10: c = 5'b10110;
      11: c = 5'b10111;
      12: c = 5'b11010;
      13: c = 5'b11011;
      14: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction

  typedef struct packed {
    logic idle;
    logic j;
    logic k;
    logic t;
    logic r;
    logic h;
    logic data;
    logic bad;
  } cg_class_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAND_J,
    ST_CAND_X,
    ST_FALSE,
    ST_FRAME,
    ST_END_T
  } rx_state_e;

endpackage

// File: rtl/cg_classify.sv
module cg_classify
  import rxmon_pkg::*;
(
  input  logic [CG_W-1:0] cg,
  output cg_class_t       cls
);

  logic [NUM_DATA-1:0] data_hit;

  // one comparator per data code group
  for (genvar g = 0; g < NUM_DATA; g++) begin : g_data
    assign data_hit[g] = (cg == data_code(g));
  end

  always_comb begin
    cls.idle = (cg == CG_IDLE);
    cls.j    = (cg == CG_J);
    cls.k    = (cg == CG_K);
    cls.t    = (cg == CG_T);
    cls.r    = (cg == CG_R);
    cls.h    = (cg == CG_H);
    cls.data = |data_hit;
    cls.bad  = !(cls.data || cls.idle || cls.j || cls.k ||
                 cls.t || cls.r || cls.h);
  end

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import rxmon_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      mode_100,
  input  logic      cg_valid,
  input  cg_class_t cls,
  output logic      ev_fc,
  output logic      ev_inv,
  output logic      ev_halt,
  output logic      in_frame,
  output logic      rx_err
);

  rx_state_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    ev_fc   = 1'b0;
    ev_inv  = 1'b0;
    ev_halt = 1'b0;
    if (cg_valid) begin
      case (st_q)
        ST_IDLE: begin
          if (!cls.idle) st_d = cls.j ? ST_CAND_J : ST_CAND_X;
        end
        ST_CAND_J: begin
          if (cls.idle)   st_d = ST_IDLE;
          else if (cls.k) st_d = ST_FRAME;
          else begin
            ev_fc = 1'b1;
            st_d  = ST_FALSE;
          end
        end
        ST_CAND_X: begin
          if (cls.idle) st_d = ST_IDLE;
          else begin
            ev_fc = 1'b1;
            st_d  = ST_FALSE;
          end
        end
        ST_FALSE: begin
          if (cls.idle) st_d = ST_IDLE;
        end
        ST_FRAME, ST_END_T: begin
          if (cls.idle)                     st_d = ST_IDLE;
          else if (st_q == ST_END_T && cls.r) st_d = ST_IDLE;
          else if (cls.t)                   st_d = ST_END_T;
          else begin
            st_d    = ST_FRAME;
            ev_halt = cls.h;
            ev_inv  = cls.bad;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
    if (!mode_100) begin
      st_d    = ST_IDLE;
      ev_fc   = 1'b0;
      ev_inv  = 1'b0;
      ev_halt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      in_frame <= 1'b0;
      rx_err   <= 1'b0;
    end else begin
      st_q     <= st_d;
      in_frame <= (st_d == ST_FRAME) || (st_d == ST_END_T);
      rx_err   <= ev_fc || ev_inv || ev_halt;
    end
  end

  // R1: a frame only opens on an accepted /K/
  a_r1_opens_on_k: assert property (@(posedge clk) disable iff (rst)
    $rose(in_frame) |-> $past(cg_valid && cls.k && mode_100));

  // R5: /T/ then /R/ closes the frame
  a_r5_tr_closes: assert property (@(posedge clk) disable iff (rst)
    (mode_100 && cg_valid && st_q == ST_END_T && cls.r) |=> !in_frame);

  // R9: slow mode keeps the receive outputs quiet
  a_r9_slow_quiet: assert property (@(posedge clk) disable iff (rst)
    !mode_100 |=> (!in_frame && !rx_err));

  // R12: an error pulse always traces back to an accepted group
  a_r12_err_from_group: assert property (@(posedge clk) disable iff (rst)
    rx_err |-> $past(cg_valid));

endmodule

// File: rtl/flag_latch.sv
module flag_latch (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic ev,
  input  logic rd_stb,
  output logic flag_q
);

  always_ff @(posedge clk) begin
    if (rst || !enable) flag_q <= 1'b0;
    else if (rd_stb)    flag_q <= ev;
    else                flag_q <= flag_q | ev;
  end

  // R6: a set flag holds without a read
  a_r6_holds: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !rd_stb && enable) |=> flag_q);

  // R7: a read with no new event clears the flag
  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !ev) |=> !flag_q);

  // R8: an event coinciding with a read is kept
  a_r8_event_kept: assert property (@(posedge clk) disable iff (rst)
    (ev && enable) |=> flag_q);

  // R9: flags are zero in slow mode
  a_r9_flag_zero: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !flag_q);

endmodule

// File: rtl/rx_symerr_mon.sv
module rx_symerr_mon #(
  parameter int STAT_W   = 16,
  parameter int FC_POS   = 8,
  parameter int INV_POS  = 7,
  parameter int HALT_POS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_100,
  input  logic              cg_valid,
  input  logic [4:0]        cg_data,
  input  logic              rd_stb,
  output logic              rx_err,
  output logic              in_frame,
  output logic [STAT_W-1:0] status_word
);
  import rxmon_pkg::*;

  localparam int NF = NUM_FLAGS;

  cg_class_t     cls;
  logic [NF-1:0] ev;
  logic [NF-1:0] flags;

  cg_classify u_cls (
    .cg  (cg_data),
    .cls (cls)
  );

  rx_frame_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .mode_100 (mode_100),
    .cg_valid (cg_valid),
    .cls      (cls),
    .ev_fc    (ev[FLG_FC]),
    .ev_inv   (ev[FLG_INV]),
    .ev_halt  (ev[FLG_HALT]),
    .in_frame (in_frame),
    .rx_err   (rx_err)
  );

  for (genvar f = 0; f < NF; f++) begin : g_flag
    flag_latch u_flag (
      .clk    (clk),
      .rst    (rst),
      .enable (mode_100),
      .ev     (ev[f]),
      .rd_stb (rd_stb),
      .flag_q (flags[f])
    );
  end

  // place each flag at its bit; all other bits are zero
  for (genvar b = 0; b < STAT_W; b++) begin : g_stat
    if (b == FC_POS) begin : g_fc
      assign status_word[b] = flags[FLG_FC];
    end else if (b == INV_POS) begin : g_inv
      assign status_word[b] = flags[FLG_INV];
    end else if (b == HALT_POS) begin : g_halt
      assign status_word[b] = flags[FLG_HALT];
    end else begin : g_zero
      assign status_word[b] = 1'b0;
    end
  end

  // R2: a false carrier event shows up both as an error pulse and in its flag
  a_r2_fc_reported: assert property (@(posedge clk) disable iff (rst)
    ev[FLG_FC] |=> (rx_err && status_word[FC_POS]));

endmodule

// File: tb/test_rx_symerr_mon.sv
module test_rx_symerr_mon;

  localparam logic [4:0] I = 5'b11111, J = 5'b11000, K = 5'b10001;
  localparam logic [4:0] T = 5'b01101, R = 5'b00111, H = 5'b00100;
  localparam logic [4:0] D0 = 5'b11110, D1 = 5'b01001, D2 = 5'b10100;
  localparam logic [4:0] D5 = 5'b01011, DA = 5'b10110;
  localparam logic [4:0] BAD0 = 5'b00000, BAD1 = 5'b11001;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_100 = 1'b1;
  logic        cg_valid = 1'b0;
  logic [4:0]  cg_data = I;
  logic        rd_stb = 1'b0;
  logic        rx_err;
  logic        in_frame;
  logic [15:0] status_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic        e;
    logic        f;
    logic [15:0] s;
    string       tag;
  } exp_t;

  exp_t q[$];

  // reference state: 0 idle, 1 J seen, 2 other seen, 3 false wait, 4 frame, 5 T seen
  int   m_st = 0;
  logic m_fc = 0, m_inv = 0, m_halt = 0;

  always #10 clk = ~clk;

  rx_symerr_mon i_rx_symerr_mon (
    .clk         (clk),
    .rst         (rst),
    .mode_100    (mode_100),
    .cg_valid    (cg_valid),
    .cg_data     (cg_data),
    .rd_stb      (rd_stb),
    .rx_err      (rx_err),
    .in_frame    (in_frame),
    .status_word (status_word)
  );

  function automatic bit is_data(logic [4:0] c);
    return c inside {5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
                     5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
                     5'b11010, 5'b11011, 5'b11100, 5'b11101};
  endfunction

  task automatic put(logic [4:0] c, logic v, logic rd, string tag);
    exp_t x;
    logic f = 0, n = 0, h = 0;
    @(negedge clk);
    cg_data  = c;
    cg_valid = v;
    rd_stb   = rd;
    if (!mode_100) begin
      m_st = 0; m_fc = 0; m_inv = 0; m_halt = 0;
    end else begin
      if (v) begin
        case (m_st)
          0: if (c != I) m_st = (c == J) ? 1 : 2;
          1: if (c == I) m_st = 0; else if (c == K) m_st = 4; else begin f = 1; m_st = 3; end
          2: if (c == I) m_st = 0; else begin f = 1; m_st = 3; end
          3: if (c == I) m_st = 0;
          default: begin
            if (c == I) m_st = 0;
            else if (m_st == 5 && c == R) m_st = 0;
            else if (c == T) m_st = 5;
            else begin
              m_st = 4;
              h = (c == H);
              n = !is_data(c) && !(c inside {J, K, R, H});
            end
          end
        endcase
      end
      if (rd) begin
        m_fc = f; m_inv = n; m_halt = h;
      end else begin
        m_fc |= f; m_inv |= n; m_halt |= h;
      end
    end
    x.e   = f | n | h;
    x.f   = (m_st == 4) || (m_st == 5);
    x.s   = 16'h0;
    x.s[8] = m_fc;
    x.s[7] = m_inv;
    x.s[6] = m_halt;
    x.tag = tag;
    q.push_back(x);
  endtask

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: compare one expected item per accepted edge
  initial begin
    exp_t x;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        x = q.pop_front();
        chk(x.tag, "rx_err",   {15'b0, rx_err},   {15'b0, x.e});
        chk(x.tag, "in_frame", {15'b0, in_frame}, {15'b0, x.f});
        chk(x.tag, "status",   status_word,       x.s);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "reset rx_err",   {15'b0, rx_err},   16'h0);
    chk("R10", "reset in_frame", {15'b0, in_frame}, 16'h0);
    chk("R10", "reset status",   status_word,       16'h0);
    rst = 1'b0;

    // R1 / R5: clean frame ended by T R
    repeat (3) put(I, 1, 0, "R1");
    put(J, 1, 0, "R1"); put(K, 1, 0, "R1");
    put(D5, 1, 0, "R1"); put(DA, 1, 0, "R1");
    put(T, 1, 0, "R5"); put(R, 1, 0, "R5");
    put(I, 1, 0, "R5"); put(I, 1, 0, "R5");

    // R5: T followed by data keeps the frame, then idle ends it
    put(J, 1, 0, "R5"); put(K, 1, 0, "R5"); put(T, 1, 0, "R5");
    put(D1, 1, 0, "R5"); put(I, 1, 0, "R5");

    // R3: invalid groups in a frame, then R6 hold, R7 read
    put(J, 1, 0, "R3"); put(K, 1, 0, "R3"); put(D0, 1, 0, "R3");
    put(BAD0, 1, 0, "R3"); put(D5, 1, 0, "R3"); put(BAD1, 1, 0, "R3");
    put(T, 1, 0, "R3"); put(R, 1, 0, "R3");
    repeat (4) put(I, 1, 0, "R6");
    put(I, 1, 1, "R7"); put(I, 1, 0, "R7");

    // R4: halt in a frame; frame ends on idle
    put(J, 1, 0, "R4"); put(K, 1, 0, "R4"); put(D5, 1, 0, "R4");
    put(H, 1, 0, "R4"); put(D0, 1, 0, "R4");
    put(I, 1, 0, "R5"); put(I, 1, 0, "R6");
    put(I, 1, 1, "R7"); put(I, 1, 0, "R7");

    // R2: false carrier from two data groups, then J not followed by K
    put(D2, 1, 0, "R2"); put(D1, 1, 0, "R2"); put(D0, 1, 0, "R2");
    put(K, 1, 0, "R2"); put(I, 1, 0, "R2"); put(I, 1, 0, "R2");
    put(I, 1, 1, "R7");
    put(J, 1, 0, "R2"); put(D0, 1, 0, "R2"); put(I, 1, 0, "R2");
    put(I, 1, 1, "R7"); put(I, 1, 0, "R7");

    // R11: single non-idle groups outside a frame
    put(BAD0, 1, 0, "R11"); put(I, 1, 0, "R11");
    put(H, 1, 0, "R11"); put(I, 1, 0, "R11");
    put(J, 1, 0, "R11"); put(I, 1, 0, "R11");

    // R8: event in the same cycle as a read
    put(J, 1, 0, "R8"); put(K, 1, 0, "R8");
    put(H, 1, 0, "R8");
    put(BAD0, 1, 1, "R8");
    put(D0, 1, 0, "R8"); put(I, 1, 0, "R8");
    put(I, 1, 1, "R7"); put(I, 1, 0, "R7");

    // R12: groups without cg_valid are ignored
    put(J, 1, 0, "R12"); put(K, 0, 0, "R12"); put(K, 1, 0, "R12");
    put(I, 0, 0, "R12"); put(BAD0, 0, 0, "R12"); put(H, 0, 0, "R12");
    put(D5, 1, 0, "R12"); put(T, 1, 0, "R12"); put(R, 0, 0, "R12");
    put(R, 1, 0, "R12"); put(I, 1, 0, "R12");

    // R9: slow mode clears a held flag and ignores the stream
    put(D2, 1, 0, "R9"); put(D1, 1, 0, "R9"); put(I, 1, 0, "R9");
    @(negedge clk); mode_100 = 1'b0;
    put(I, 1, 0, "R9"); put(J, 1, 0, "R9"); put(K, 1, 0, "R9");
    put(BAD0, 1, 0, "R9"); put(H, 1, 0, "R9"); put(D2, 1, 1, "R9");
    put(D1, 1, 0, "R9"); put(T, 1, 0, "R9");
    @(negedge clk); mode_100 = 1'b1;
    put(I, 1, 0, "R9"); put(J, 1, 0, "R9"); put(K, 1, 0, "R9");
    put(H, 1, 0, "R9"); put(I, 1, 0, "R9");

    put(I, 0, 0, "R10");
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule